// File: doc/BRIEF.md
# Power and Reset Sequencer

This block sits behind a write-only system power control byte. A write carries request bits that are decoded into a power-off request, a sleep notice and three reset actions. The three reset actions are a full reboot, a normal reboot and a memory-only reset. The block drives three active-low reset lines: core, secondary and memory. Once a reset request is accepted, the asserted lines are held low for a fixed hold time and then released together. After a second, longer delay the block pulses a re-initialisation strobe.

A legacy-mode input changes the normal reboot so that it also resets memory. The normal reboot also emits a one-cycle strobe that clears the legacy-emulation register set. The power-off and sleep requests only produce one-cycle pulses. While a reset sequence is running, the block reports busy and ignores every write.

Top module: `pwr_rst_seq`

## Requirements
- R1: After reset, core_rst_n, sec_rst_n and mem_rst_n are 1, and poweroff_pulse, sleep_pulse, legacy_clr_pulse, reinit_pulse and busy are 0.
- R2: An accepted write with data bit 0 set raises poweroff_pulse for exactly the one cycle after the write edge. If no reset bit (1, 2 or 3) is also set, no reset line moves and busy stays 0.
- R3: An accepted write with data bit 1 set (full reboot) drives core_rst_n, sec_rst_n and mem_rst_n to 0 from the write edge.
- R4: An accepted write with data bit 2 set (normal reboot) drives sec_rst_n to 0. It drives mem_rst_n to 0 only if legacy_mode is 1 at the write edge. It also raises legacy_clr_pulse for one cycle.
- R5: An accepted write with only data bit 3 set drives mem_rst_n to 0 and leaves core_rst_n and sec_rst_n at 1.
- R6: When several request bits are set in one write, the lines driven low are the union of the lines each bit asserts, and the pulses of all set bits appear together.
- R7: Every reset line driven low stays low for exactly HOLD_CYC cycles. All such lines return to 1 on the same edge.
- R8: reinit_pulse is 1 for one cycle, exactly REINIT_CYC cycles after the lines are released. busy falls on that same edge.
- R9: An accepted write with data bit 4 set raises sleep_pulse for one cycle. Bit 4 moves no reset line and does not set busy.
- R10: Data bits 7 to 5 have no effect on any output.
- R11: A write while busy is 1 is ignored. It produces no pulse, and it neither changes the reset lines nor the sequence timing.
- R12: HOLD_CYC equals CLK_KHZ*HOLD_MS and REINIT_CYC equals CLK_KHZ*REINIT_MS, with defaults of 5 ms and 100 ms.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for the control byte |
| wr_data | input | DW | Control byte: bit0 power-off, bit1 full reboot, bit2 normal reboot, bit3 memory reset, bit4 sleep |
| legacy_mode | input | 1 | Legacy mode flag; adds the memory reset to a normal reboot |
| core_rst_n | output | 1 | Core reset, active low |
| sec_rst_n | output | 1 | Secondary reset, active low |
| mem_rst_n | output | 1 | Memory reset, active low |
| poweroff_pulse | output | 1 | One-cycle power-off request |
| sleep_pulse | output | 1 | One-cycle sleep notice |
| legacy_clr_pulse | output | 1 | One-cycle clear of the legacy-emulation registers |
| reinit_pulse | output | 1 | One-cycle re-initialisation strobe |
| busy | output | 1 | A reset sequence is active |

## Verification
The bench builds the block with CLK_KHZ set to 2. This makes the hold window 10 cycles and the re-init delay 200 cycles, so a complete sequence takes about 210 cycles. At that length, each request kind, both legacy settings, a combined request and writes during the hold and wait phases all fit in one short run. The hold length is also measured on the ports and compared against the value derived from the clock parameter.

// File: rtl/pwr_rst_pkg.sv
package pwr_rst_pkg;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_HOLD = 2'd1,
    PH_WAIT = 2'd2
  } phase_e;

  typedef struct packed {
    logic core;
    logic sec;
    logic mem;
  } rst_set_t;

  typedef struct packed {
    rst_set_t rst;
    logic     poweroff;
    logic     sleep;
    logic     lgy_clr;
  } req_t;

  localparam int BIT_OFF   = 0;
  localparam int BIT_FULL  = 1;
  localparam int BIT_NORM  = 2;
  localparam int BIT_MEM   = 3;
  localparam int BIT_SLEEP = 4;

endpackage

// File: rtl/pwr_req_decode.sv
module pwr_req_decode
  import pwr_rst_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic [DW-1:0] data,
  input  logic          legacy,
  output req_t          req
);

  logic unused_hi_bits;
  assign unused_hi_bits = ^data[DW-1:BIT_SLEEP+1];

  always_comb begin
    req.poweroff = data[BIT_OFF];
    req.sleep    = data[BIT_SLEEP];
    req.lgy_clr  = data[BIT_NORM];
    req.rst.core = data[BIT_FULL];
    req.rst.sec  = data[BIT_FULL] | data[BIT_NORM];
    req.rst.mem  = data[BIT_FULL] | data[BIT_MEM] | (data[BIT_NORM] & legacy);
  end

endmodule

// File: rtl/pwr_phase_timer.sv
module pwr_phase_timer #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [CW-1:0] len,
  output logic          expire
);

  logic [CW-1:0] cnt;
  logic          running;

  assign expire = running && (cnt == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt     <= '0;
      running <= 1'b0;
    end else if (start) begin
      cnt     <= len - 1'b1;
      running <= 1'b1;
    end else if (running) begin
      if (cnt == '0) running <= 1'b0;
      else           cnt     <= cnt - 1'b1;
    end
  end

endmodule

// File: rtl/pwr_rst_seq.sv
module pwr_rst_seq
  import pwr_rst_pkg::*;
#(
  parameter int DW        = 8,
  parameter int CLK_KHZ   = 50000,
  parameter int HOLD_MS   = 5,
  parameter int REINIT_MS = 100
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic          legacy_mode,
  output logic          core_rst_n,
  output logic          sec_rst_n,
  output logic          mem_rst_n,
  output logic          poweroff_pulse,
  output logic          sleep_pulse,
  output logic          legacy_clr_pulse,
  output logic          reinit_pulse,
  output logic          busy
);

  localparam int HOLD_CYC   = CLK_KHZ * HOLD_MS;
  localparam int REINIT_CYC = CLK_KHZ * REINIT_MS;
  localparam int MAX_CYC    = (HOLD_CYC > REINIT_CYC) ? HOLD_CYC : REINIT_CYC;
  localparam int CW         = $clog2(MAX_CYC + 1);

  phase_e        phase;
  req_t          req;
  logic          accept;
  logic          any_rst;
  logic          tmr_start;
  logic          tmr_expire;
  logic [CW-1:0] tmr_len;

  pwr_req_decode #(.DW(DW)) i_decode (
    .data   (wr_data),
    .legacy (legacy_mode),
    .req    (req)
  );

  assign accept    = wr_en && (phase == PH_IDLE);
  assign any_rst   = |req.rst;
  assign tmr_start = (accept && any_rst) || ((phase == PH_HOLD) && tmr_expire);
  assign tmr_len   = (phase == PH_IDLE) ? CW'(HOLD_CYC) : CW'(REINIT_CYC);

  pwr_phase_timer #(.CW(CW)) i_timer (
    .clk    (clk),
    .rst    (rst),
    .start  (tmr_start),
    .len    (tmr_len),
    .expire (tmr_expire)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      phase            <= PH_IDLE;
      core_rst_n       <= 1'b1;
      sec_rst_n        <= 1'b1;
      mem_rst_n        <= 1'b1;
      poweroff_pulse   <= 1'b0;
      sleep_pulse      <= 1'b0;
      legacy_clr_pulse <= 1'b0;
      reinit_pulse     <= 1'b0;
      busy             <= 1'b0;
    end else begin
      poweroff_pulse   <= accept && req.poweroff;
      sleep_pulse      <= accept && req.sleep;
      legacy_clr_pulse <= accept && req.lgy_clr;
      reinit_pulse     <= 1'b0;
      unique case (phase)
        PH_IDLE: begin
          if (accept && any_rst) begin
            phase      <= PH_HOLD;
            busy       <= 1'b1;
            core_rst_n <= ~req.rst.core;
            sec_rst_n  <= ~req.rst.sec;
            mem_rst_n  <= ~req.rst.mem;
          end
        end
        PH_HOLD: begin
          if (tmr_expire) begin
            phase      <= PH_WAIT;
            core_rst_n <= 1'b1;
            sec_rst_n  <= 1'b1;
            mem_rst_n  <= 1'b1;
          end
        end
        PH_WAIT: begin
          if (tmr_expire) begin
            phase        <= PH_IDLE;
            busy         <= 1'b0;
            reinit_pulse <= 1'b1;
          end
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/pwr_rst_seq_chk.sv
module pwr_rst_seq_chk #(
  parameter int DW      = 8,
  parameter int CLK_KHZ = 50000,
  parameter int HOLD_MS = 5
) (
  input logic          clk,
  input logic          rst,
  input logic          wr_en,
  input logic [DW-1:0] wr_data,
  input logic          core_rst_n,
  input logic          sec_rst_n,
  input logic          mem_rst_n,
  input logic          poweroff_pulse,
  input logic          sleep_pulse,
  input logic          legacy_clr_pulse,
  input logic          reinit_pulse,
  input logic          busy
);

  localparam int HOLD_CYC = CLK_KHZ * HOLD_MS;

  logic        all_high;
  logic [31:0] low_cnt;

  assign all_high = core_rst_n && sec_rst_n && mem_rst_n;

  always_ff @(posedge clk) begin
    if (rst)            low_cnt <= '0;
    else if (!all_high) low_cnt <= low_cnt + 1;
    else                low_cnt <= '0;
  end

  p_poweroff_cause_r2: assert property (@(posedge clk) disable iff (rst)
    poweroff_pulse |-> $past(wr_en && wr_data[0] && !busy));

  p_sleep_cause_r9: assert property (@(posedge clk) disable iff (rst)
    sleep_pulse |-> $past(wr_en && wr_data[4] && !busy));

  p_release_together_r7: assert property (@(posedge clk) disable iff (rst)
    ($rose(core_rst_n) || $rose(sec_rst_n) || $rose(mem_rst_n)) |-> all_high);

  p_hold_len_r7: assert property (@(posedge clk) disable iff (rst)
    ($past(!all_high) && all_high) |-> (low_cnt == HOLD_CYC));

  p_reinit_end_r8: assert property (@(posedge clk) disable iff (rst)
    reinit_pulse |-> (!busy && $past(busy)));

  p_idle_lines_high_r8: assert property (@(posedge clk) disable iff (rst)
    !busy |-> all_high);

  p_ignore_busy_r11: assert property (@(posedge clk) disable iff (rst)
    $past(busy) |-> (!poweroff_pulse && !sleep_pulse && !legacy_clr_pulse));

endmodule

bind pwr_rst_seq pwr_rst_seq_chk #(
  .DW(DW), .CLK_KHZ(CLK_KHZ), .HOLD_MS(HOLD_MS)
) i_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
  .core_rst_n(core_rst_n), .sec_rst_n(sec_rst_n), .mem_rst_n(mem_rst_n),
  .poweroff_pulse(poweroff_pulse), .sleep_pulse(sleep_pulse),
  .legacy_clr_pulse(legacy_clr_pulse), .reinit_pulse(reinit_pulse),
  .busy(busy)
);

// File: tb/test_pwr_rst_seq.sv
`timescale 1ns/1ps
module test_pwr_rst_seq;

  localparam int DW         = 8;
  localparam int CLK_KHZ    = 2;
  localparam int HOLD_CYC   = CLK_KHZ * 5;
  localparam int REINIT_CYC = CLK_KHZ * 100;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en = 1'b0;
  logic [DW-1:0] wr_data = '0;
  logic legacy_mode = 1'b0;
  logic core_rst_n, sec_rst_n, mem_rst_n;
  logic poweroff_pulse, sleep_pulse, legacy_clr_pulse, reinit_pulse, busy;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  pwr_rst_seq #(.DW(DW), .CLK_KHZ(CLK_KHZ)) i_pwr_rst_seq (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
    .legacy_mode(legacy_mode), .core_rst_n(core_rst_n),
    .sec_rst_n(sec_rst_n), .mem_rst_n(mem_rst_n),
    .poweroff_pulse(poweroff_pulse), .sleep_pulse(sleep_pulse),
    .legacy_clr_pulse(legacy_clr_pulse), .reinit_pulse(reinit_pulse),
    .busy(busy)
  );

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // Behavioural reference model
  bit m_busy, e_core, e_sec, e_mem, e_po, e_sl, e_lc, e_ri;
  int hold_left, wait_left;

  always @(posedge clk) begin
    if (rst) begin
      m_busy = 0; e_core = 1; e_sec = 1; e_mem = 1;
      e_po = 0; e_sl = 0; e_lc = 0; e_ri = 0; hold_left = 0; wait_left = 0;
    end else begin
      e_po = 0; e_sl = 0; e_lc = 0; e_ri = 0;
      if (m_busy) begin
        if (hold_left > 0) begin
          hold_left--;
          if (hold_left == 0) begin
            e_core = 1; e_sec = 1; e_mem = 1; wait_left = REINIT_CYC;
          end
        end else begin
          wait_left--;
          if (wait_left == 0) begin m_busy = 0; e_ri = 1; end
        end
      end else if (wr_en) begin
        e_po = wr_data[0];
        e_sl = wr_data[4];
        e_lc = wr_data[2];
        if (wr_data[1]) begin e_core = 0; e_sec = 0; e_mem = 0; end
        if (wr_data[2]) begin e_sec = 0; if (legacy_mode) e_mem = 0; end
        if (wr_data[3]) e_mem = 0;
        if (wr_data[3:1] != 3'b000) begin m_busy = 1; hold_left = HOLD_CYC; end
      end
    end
  end

  always @(negedge clk) begin
    if (!rst && !done) begin
      check("R2 poweroff_pulse", int'(poweroff_pulse), int'(e_po));
      check("R9 sleep_pulse", int'(sleep_pulse), int'(e_sl));
      check("R4 legacy_clr_pulse", int'(legacy_clr_pulse), int'(e_lc));
      check("R8 reinit_pulse", int'(reinit_pulse), int'(e_ri));
      check("R11 busy", int'(busy), int'(m_busy));
      check("R7 reset lines", int'({core_rst_n, sec_rst_n, mem_rst_n}),
            int'({e_core, e_sec, e_mem}));
    end
  end

  task automatic wr(logic [DW-1:0] d);
    @(negedge clk); wr_en = 1'b1; wr_data = d;
    @(negedge clk); wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 1000 && busy; i++) @(negedge clk);
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    #(4 * 20000);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    int lowcnt;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    check("R1 rst lines", int'({core_rst_n, sec_rst_n, mem_rst_n}), 7);
    check("R1 pulses", int'({poweroff_pulse, sleep_pulse, legacy_clr_pulse, reinit_pulse}), 0);
    check("R1 busy", int'(busy), 0);

    wr(8'h01);
    check("R2 poweroff", int'(poweroff_pulse), 1);
    check("R2 no busy", int'(busy), 0);
    @(negedge clk);
    check("R2 single cycle", int'(poweroff_pulse), 0);

    wr(8'h10);
    check("R9 sleep", int'(sleep_pulse), 1);
    check("R9 lines", int'({core_rst_n, sec_rst_n, mem_rst_n, busy}), 14);

    wr(8'hE0);
    check("R10 no effect", int'({core_rst_n, sec_rst_n, mem_rst_n, busy,
          poweroff_pulse, sleep_pulse, legacy_clr_pulse}), 7'b1110000);

    legacy_mode = 1'b0;
    wr(8'h02);
    check("R3 full reboot", int'({core_rst_n, sec_rst_n, mem_rst_n}), 0);
    lowcnt = 0;
    for (int i = 0; i < 100 && !core_rst_n; i++) begin lowcnt++; @(negedge clk); end
    check("R12 hold length", lowcnt, HOLD_CYC);
    wait_idle();

    wr(8'h04);
    check("R4 normal no legacy", int'({core_rst_n, sec_rst_n, mem_rst_n}), 3'b101);
    check("R4 clear pulse", int'(legacy_clr_pulse), 1);
    wait_idle();

    legacy_mode = 1'b1;
    wr(8'h04);
    check("R4 normal legacy", int'({core_rst_n, sec_rst_n, mem_rst_n}), 3'b100);
    legacy_mode = 1'b0;
    wr(8'h11);
    check("R11 ignored in hold", int'({poweroff_pulse, sleep_pulse}), 0);
    repeat (HOLD_CYC + 5) @(negedge clk);
    wr(8'h0F);
    check("R11 ignored in wait", int'({core_rst_n, sec_rst_n, mem_rst_n, legacy_clr_pulse}), 4'b1110);
    wait_idle();

    wr(8'h08);
    check("R5 memory only", int'({core_rst_n, sec_rst_n, mem_rst_n}), 3'b110);
    wait_idle();

    wr(8'h0D);
    check("R6 union lines", int'({core_rst_n, sec_rst_n, mem_rst_n}), 3'b100);
    check("R6 union pulses", int'({poweroff_pulse, legacy_clr_pulse}), 3);
    wait_idle();
    repeat (3) @(negedge clk);

    done = 1'b1;
    summary();
    $finish;
  end

endmodule